// File: doc/BRIEF.md
# Write-Cycle Qualifier for a Byte-Wide Flash Command Port

This block sits between the active-low control pins of a byte-wide nonvolatile memory and its command register. It decides which pin activity counts as a real write. The chip-enable, write-enable and output-enable pins are brought into the system clock domain and cleaned of short pulses. A write opens only when the cleaned pins show chip-enable low, write-enable low and output-enable high. When a write opens, the block captures the address and data. When write-enable or chip-enable later returns high, it issues a one-cycle strobe to the command logic.

Two conditions lock writes out. The first is a digital supply-lockout input. The second is the power-up reset. In either case the block tells the command logic to go back to read mode and drops every write. It accepts no new write until the lockout has ended and chip-enable or write-enable has been seen high. A write that is already on the pins when the lockout ends is therefore never taken. Glitch filtering uses `GLITCH_CYC` consecutive samples of the synchronized pin.

Top module: `wr_inhibit_ctrl`

## Requirements
- R1: A write opens when the filtered pins show chip-enable low (0), write-enable low (0) and output-enable high (1). At that moment `wr_addr_o` and `wr_data_o` capture `addr_i` and `data_i`. When the filtered chip-enable or write-enable goes high again, `wr_strobe_o` pulses.
- R2: Chip-enable high, write-enable high or output-enable low inhibits a write. Any one of them alone is enough, and no strobe follows.
- R3: When all three pins are low together, the access is a read and no strobe follows.
- R4: No strobe is issued while `lockout_i` is high, and any open write is dropped.
- R5: A write pattern present on the pins when reset is released is not accepted.
- R6: A pin change shorter than `GLITCH_CYC` clock cycles has no effect. A write pattern held for exactly `GLITCH_CYC` cycles is accepted.
- R7: `wr_strobe_o` is never high for two cycles in a row.
- R8: `read_rst_o` pulses for one cycle after reset is released. It also pulses once each time `lockout_i` rises, three clock edges after the rise is sampled.
- R9: After lockout ends, a write pattern held through the release is not accepted. Writes are re-armed only once chip-enable or write-enable has been seen high.
- R10: If output-enable goes low while a write is open, the write is cancelled without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| lockout_i | input | 1 | Supply-lockout indication, active high |
| ce_n_i | input | 1 | Chip-enable pin, active low |
| we_n_i | input | 1 | Write-enable pin, active low |
| oe_n_i | input | 1 | Output-enable pin, active low |
| addr_i | input | AW | Address bus |
| data_i | input | DW | Data bus |
| wr_strobe_o | output | 1 | One-cycle accepted-write strobe |
| wr_addr_o | output | AW | Address captured at write start |
| wr_data_o | output | DW | Data captured at write start |
| read_rst_o | output | 1 | One-cycle return-to-read-mode pulse |

## Verification
A vector table drives the block with several pin combinations, and the strobe count and captured address separate them:
- a clean write;
- the three-low read;
- a write with chip-enable held high;
- a write with write-enable held high;
- a one-cycle write pulse, which must be rejected;
- a write pattern lasting exactly the threshold, which must be accepted.

Directed sequences then cover three cases that would otherwise look alike:
- a write cancelled by output-enable;
- a write cut off by lockout, compared with a write held across lockout release;
- a write held across the end of power-up reset.

In each case a later normal write must still be accepted, so a block that ignores everything cannot pass.

// File: rtl/wr_inhibit_ctrl.sv
module wr_inhibit_ctrl #(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int GLITCH_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lockout_i,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_strobe_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          read_rst_o
);
  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam int NP = 3;

  logic [NP-1:0] pin_s1, pin_s2, pin_f;
  logic [CW-1:0] run_cnt [NP];
  logic          lk_s1, lk_s2, lk_d, booted, armed, in_wr;

  // bit 0 chip-enable, bit 1 write-enable, bit 2 output-enable; reset to low so a high must be seen
  wire wr_pins  = !pin_f[0] && !pin_f[1] && pin_f[2];
  wire released = pin_f[0] || pin_f[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
      pin_f  <= '0;
      for (int i = 0; i < NP; i++) run_cnt[i] <= '0;
    end else begin
      pin_s1 <= {oe_n_i, we_n_i, ce_n_i};
      pin_s2 <= pin_s1;
      for (int i = 0; i < NP; i++) begin
        if (pin_s2[i] != pin_f[i]) begin
          if (run_cnt[i] == CW'(GLITCH_CYC - 1)) begin
            pin_f[i]   <= pin_s2[i];
            run_cnt[i] <= '0;
          end else begin
            run_cnt[i] <= run_cnt[i] + 1'b1;
          end
        end else begin
          run_cnt[i] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_s1      <= 1'b0;
      lk_s2      <= 1'b0;
      lk_d       <= 1'b0;
      booted     <= 1'b0;
      read_rst_o <= 1'b0;
    end else begin
      lk_s1      <= lockout_i;
      lk_s2      <= lk_s1;
      lk_d       <= lk_s2;
      booted     <= 1'b1;
      read_rst_o <= !booted || (lk_s2 && !lk_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      in_wr       <= 1'b0;
      wr_strobe_o <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
    end else begin
      wr_strobe_o <= 1'b0;
      if (lk_s2) begin
        armed <= 1'b0;
        in_wr <= 1'b0;
      end else begin
        if (released) armed <= 1'b1;
        if (!in_wr) begin
          if (armed && wr_pins) begin
            in_wr     <= 1'b1;
            wr_addr_o <= addr_i;
            wr_data_o <= data_i;
          end
        end else if (!pin_f[2]) begin
          in_wr <= 1'b0;
        end else if (released) begin
          in_wr       <= 1'b0;
          wr_strobe_o <= 1'b1;
        end
      end
    end
  end
endmodule

module wr_inhibit_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic lockout_i,
  input logic wr_strobe_o,
  input logic read_rst_o
);
  a_r7_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |=> !wr_strobe_o);

  a_r8_read_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    read_rst_o |=> !read_rst_o);

  a_r8_lockout_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout_i) |-> ##3 read_rst_o);

  a_r4_no_strobe_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lockout_i, 2) && $past(lockout_i, 3) && $past(lockout_i, 4)) |-> !wr_strobe_o);
endmodule

bind wr_inhibit_ctrl wr_inhibit_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .lockout_i(lockout_i),
  .wr_strobe_o(wr_strobe_o), .read_rst_o(read_rst_o)
);

// File: tb/wr_inhibit_ctrl_tb_top.sv
module wr_inhibit_ctrl_tb_top;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lockout_i = 1'b0;
  logic ce_n_i = 1'b1, we_n_i = 1'b1, oe_n_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic wr_strobe_o, read_rst_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;

  int total = 0, bad = 0, n_stb = 0, n_rr = 0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  bit done = 0;

  always #2 clk = ~clk;

  wr_inhibit_ctrl #(.AW(AW), .DW(DW), .GLITCH_CYC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .lockout_i(lockout_i),
    .ce_n_i(ce_n_i), .we_n_i(we_n_i), .oe_n_i(oe_n_i),
    .addr_i(addr_i), .data_i(data_i),
    .wr_strobe_o(wr_strobe_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .read_rst_o(read_rst_o)
  );

  always @(negedge clk) if (rst_n) begin
    if (wr_strobe_o) begin
      n_stb++;
      last_addr = wr_addr_o;
      last_data = wr_data_o;
    end
    if (read_rst_o) n_rr++;
  end

  // {ce, we, oe, len[3:0], expected strobes}
  localparam logic [7:0] VEC [NV] = '{
    {3'b001, 4'd6, 1'b1},  // R1 clean write
    {3'b000, 4'd6, 1'b0},  // R3 all low read
    {3'b101, 4'd6, 1'b0},  // R2 chip-enable high
    {3'b011, 4'd6, 1'b0},  // R2 write-enable high
    {3'b001, 4'd1, 1'b0},  // R6 one-cycle glitch
    {3'b001, 4'd2, 1'b1}   // R6 exactly threshold
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pins(input logic ce, input logic we, input logic oe, input int n);
    ce_n_i = ce; we_n_i = we; oe_n_i = oe;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input int a, input int len, input int exp_n, input string tag);
    int s0 = n_stb;
    addr_i = AW'(a); data_i = DW'(a);
    pins(1, 1, 1, 6);
    pins(0, 0, 1, len);
    pins(1, 1, 1, 10);
    check(n_stb - s0 == exp_n, tag, n_stb - s0, exp_n);
    if (exp_n == 1) check(last_addr == AW'(a) && last_data == DW'(a), tag, int'(last_addr), a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0, r0;
    repeat (3) @(negedge clk);
    check(wr_strobe_o == 0 && read_rst_o == 0, "reset state R7", int'(wr_strobe_o), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(n_rr == 1, "R8 boot pulse", n_rr, 1);

    for (int i = 0; i < NV; i++) begin
      s0 = n_stb;
      addr_i = AW'(16'h100 + i); data_i = DW'(8'hA0 + i);
      pins(1, 1, 1, 6);
      pins(VEC[i][7], VEC[i][6], VEC[i][5], int'(VEC[i][4:1]));
      pins(1, 1, 1, 10);
      check(n_stb - s0 == int'(VEC[i][0]), $sformatf("vector %0d R1 R2 R3 R6", i), n_stb - s0, int'(VEC[i][0]));
      if (VEC[i][0])
        check(last_addr == AW'(16'h100 + i) && last_data == DW'(8'hA0 + i),
              $sformatf("vector %0d R1 capture", i), int'(last_addr), 16'h100 + i);
    end

    // R10 output-enable cancels an open write
    s0 = n_stb;
    pins(0, 0, 1, 8);
    pins(0, 0, 0, 6);
    pins(1, 1, 1, 10);
    check(n_stb == s0, "R10 oe cancel", n_stb - s0, 0);
    do_write(16'h2A, 6, 1, "R10 write after cancel");

    // R4 lockout during an open write
    s0 = n_stb; r0 = n_rr;
    pins(0, 0, 1, 8);
    lockout_i = 1;
    repeat (4) @(negedge clk);
    pins(1, 1, 1, 10);
    check(n_stb == s0, "R4 lockout drops write", n_stb - s0, 0);
    check(n_rr - r0 == 1, "R8 lockout pulse", n_rr - r0, 1);
    do_write(16'h33, 6, 0, "R4 write during lockout");

    // R9 write held across lockout release
    s0 = n_stb;
    pins(0, 0, 1, 4);
    lockout_i = 0;
    repeat (12) @(negedge clk);
    pins(1, 1, 1, 10);
    check(n_stb == s0, "R9 held across release", n_stb - s0, 0);
    do_write(16'h44, 6, 1, "R9 rearmed write");

    // R5 write held across power-up reset
    s0 = n_stb; r0 = n_rr;
    ce_n_i = 0; we_n_i = 0; oe_n_i = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (12) @(negedge clk);
    pins(1, 1, 1, 10);
    check(n_stb == s0, "R5 held across reset", n_stb - s0, 0);
    check(n_rr - r0 == 1, "R8 second boot pulse", n_rr - r0, 1);
    do_write(16'h55, 6, 1, "R5 write after power-up");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule